// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents a single request to the processor. The request is a 3-bit interrupt level and an 8-bit vector number. Each source has an 8-bit control register. Its low five bits act as an arbitration key, and its upper three key bits are the level it requests. One further bit makes the source autovectored. A mask register can block any source. Among the pending, unmasked sources, the one with the largest key wins.

A winner with an autovector request gets a vector of 24 plus its level. Otherwise the vector comes from a register specific to that source: one for the software watchdog (source 8), and one for each of two serial peripherals (sources 12 and 13). Any other source without autovector yields the fixed vector 0x0F. If the winning key is below 4, the request is suppressed.

A byte-offset register port gives write and read access to the control, mask and vector registers, and read access to the pending register. The level and vector outputs are registered, so they reflect the register state one clock earlier.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the mask reads 0x3FFE and the watchdog vector reads 0x0F. The peripheral vectors read 0x00. The control registers of sources 1..13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. Level and vector are 0.
- R2: Pending bit n (n = 1..13) equals irq_i[n] as sampled at the previous clock edge, and bit 0 reads 0. A write to the pending offset 0x3A changes nothing.
- R3: A source whose mask bit n is 1 takes no part in arbitration.
- R4: Among pending unmasked sources, the one whose control bits [4:0] form the largest key wins. On equal keys the lowest-numbered source wins.
- R5: If no source is active, or the winning key is below 4, the level and the vector are both 0.
- R6: A winner with control bit 7 set drives level = control bits [4:2] and vector = 24 + level.
- R7: A winner with control bit 7 clear drives level = control bits [4:2]. Its vector is the watchdog vector register for source 8, peripheral vector 0 for source 12, peripheral vector 1 for source 13, and 0x0F for every other source.
- R8: Register map, byte offsets:
  - control register n at 0x13+n, 8 bits from wdata[7:0];
  - mask at 0x36, 14 bits from wdata[13:0];
  - pending at 0x3A, read only;
  - watchdog vector at 0x42;
  - peripheral vector 0 at 0x170;
  - peripheral vector 1 at 0x1B0.
  
  Vector registers take wdata[7:0]. Unmapped offsets read 0.
- R9: Level and vector change exactly one clock after a change of the pending, mask, control or vector registers, and hold while those registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 14 | Level interrupt sources; bit n is source n, bit 0 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from offset) |
| irq_level_o | output | 3 | Requested interrupt level, 0 = none |
| irq_vector_o | output | 8 | Vector number for the request |

## Verification
The assertions check four behaviours on every cycle:
- a zero level always carries a zero vector;
- an all-masked state leaves the request idle on the next cycle;
- pending tracks the inputs one cycle late;
- the outputs hold whenever the registers hold, and a nonzero level only follows a cycle with an active source.

Only the bench's scenarios can show:
- which source wins among several, including equal-key ties;
- the exact vector chosen for each source class;
- the key-4 suppression threshold;
- the reset contents of the register map;
- the one-cycle output latency after a mask write.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int CTRL_W       = 8;
  localparam int KEY_W        = 5;
  localparam int LVL_W        = 3;
  localparam int VEC_W        = 8;
  localparam int MIN_KEY      = 4;
  localparam int AUTOVEC_BASE = 24;
  localparam int DEFAULT_VEC  = 'h0F;
  localparam int WDOG_SRC     = 8;
  localparam int PERIPH0_SRC  = 12;
  localparam int PERIPH1_SRC  = 13;

  localparam int CTRL_BASE    = 'h013;
  localparam int MASK_OFS     = 'h036;
  localparam int PEND_OFS     = 'h03A;
  localparam int WDOG_OFS     = 'h042;
  localparam int PVEC0_OFS    = 'h170;
  localparam int PVEC1_OFS    = 'h1B0;

  localparam logic [VEC_W-1:0] WDOG_RST = 8'h0F;

  function automatic logic [CTRL_W-1:0] ctrl_reset(int n);
    if (n >= 1 && n <= 7) return CTRL_W'(n * 4);
    if (n == 8)           return 8'h1C;
    if (n >= 9 && n <= 11) return 8'h80;
    return '0;
  endfunction
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16,
  localparam int MASK_W = NUM_SRC + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC:0]              src_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_SRC:0]              pend_o,
  output logic [MASK_W-1:0]             mask_o,
  output logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_o,
  output logic [VEC_W-1:0]              wdog_vec_o,
  output logic [VEC_W-1:0]              pvec0_o,
  output logic [VEC_W-1:0]              pvec1_o
);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] PEND_A  = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] WDOG_A  = ADDR_W'(WDOG_OFS);
  localparam logic [ADDR_W-1:0] PVEC0_A = ADDR_W'(PVEC0_OFS);
  localparam logic [ADDR_W-1:0] PVEC1_A = ADDR_W'(PVEC1_OFS);

  logic [NUM_SRC:1]             pend_q;
  logic [MASK_W-1:0]            mask_q;
  logic [NUM_SRC:1][CTRL_W-1:0] ctrl_q;
  logic [VEC_W-1:0]             wdog_q, pvec0_q, pvec1_q;
  logic                         unused_bits;

  assign unused_bits = ^{src_i[0], wdata_i[DATA_W-1:MASK_W]};

  // level sources: pending mirrors the inputs, no latching
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= src_i[NUM_SRC:1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= {{NUM_SRC{1'b1}}, 1'b0};
      wdog_q  <= WDOG_RST;
      pvec0_q <= '0;
      pvec1_q <= '0;
    end else if (we_i) begin
      if (addr_i == MASK_A)  mask_q  <= wdata_i[MASK_W-1:0];
      if (addr_i == WDOG_A)  wdog_q  <= wdata_i[VEC_W-1:0];
      if (addr_i == PVEC0_A) pvec0_q <= wdata_i[VEC_W-1:0];
      if (addr_i == PVEC1_A) pvec1_q <= wdata_i[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 1; n <= NUM_SRC; n++) ctrl_q[n] <= ctrl_reset(n);
    end else if (we_i) begin
      for (int n = 1; n <= NUM_SRC; n++)
        if (addr_i == ADDR_W'(CTRL_BASE + n)) ctrl_q[n] <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 1; n <= NUM_SRC; n++)
      if (addr_i == ADDR_W'(CTRL_BASE + n)) rdata_o = DATA_W'(ctrl_q[n]);
    if (addr_i == MASK_A)  rdata_o = DATA_W'(mask_q);
    if (addr_i == PEND_A)  rdata_o = DATA_W'({pend_q, 1'b0});
    if (addr_i == WDOG_A)  rdata_o = DATA_W'(wdog_q);
    if (addr_i == PVEC0_A) rdata_o = DATA_W'(pvec0_q);
    if (addr_i == PVEC1_A) rdata_o = DATA_W'(pvec1_q);
  end

  assign pend_o     = {pend_q, 1'b0};
  assign mask_o     = mask_q;
  assign ctrl_o     = ctrl_q;
  assign wdog_vec_o = wdog_q;
  assign pvec0_o    = pvec0_q;
  assign pvec1_o    = pvec1_q;
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:0]              pend_i,
  input  logic [NUM_SRC:0]              mask_i,
  input  logic [NUM_SRC:1][CTRL_W-1:0]  ctrl_i,
  output logic                          win_valid_o,
  output logic [IDX_W-1:0]              win_idx_o,
  output logic [CTRL_W-1:0]             win_ctrl_o
);
  logic [KEY_W-1:0] best_key;
  logic             unused_bits;

  assign unused_bits = pend_i[0] ^ mask_i[0];

  // strict compare keeps the lowest index on equal keys
  always_comb begin
    best_key   = '0;
    win_idx_o  = '0;
    win_ctrl_o = '0;
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (pend_i[n] && !mask_i[n] && (ctrl_i[n][KEY_W-1:0] > best_key)) begin
        best_key   = ctrl_i[n][KEY_W-1:0];
        win_idx_o  = IDX_W'(n);
        win_ctrl_o = ctrl_i[n];
      end
    end
    win_valid_o = (best_key >= KEY_W'(MIN_KEY));
  end
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_valid_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [CTRL_W-1:0] win_ctrl_i,
  input  logic [VEC_W-1:0]  wdog_vec_i,
  input  logic [VEC_W-1:0]  pvec0_i,
  input  logic [VEC_W-1:0]  pvec1_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;
  logic             unused_bits;

  assign unused_bits = ^{win_ctrl_i[6:5], win_ctrl_i[1:0]};

  always_comb begin
    lvl_d = win_ctrl_i[4:2];
    if (win_ctrl_i[7]) begin
      vec_d = VEC_W'(AUTOVEC_BASE) + VEC_W'(lvl_d);
    end else begin
      if      (win_idx_i == IDX_W'(WDOG_SRC))    vec_d = wdog_vec_i;
      else if (win_idx_i == IDX_W'(PERIPH0_SRC)) vec_d = pvec0_i;
      else if (win_idx_i == IDX_W'(PERIPH1_SRC)) vec_d = pvec1_i;
      else                                       vec_d = VEC_W'(DEFAULT_VEC);
    end
    if (!win_valid_i) begin
      lvl_d = '0;
      vec_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= lvl_d;
      vector_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC:0]  irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [VEC_W-1:0]  irq_vector_o
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:0]             pend;
  logic [NUM_SRC:0]             mask;
  logic [NUM_SRC:1][CTRL_W-1:0] ctrl;
  logic [VEC_W-1:0]             wdog_vec, pvec0, pvec1;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  logic [CTRL_W-1:0]            win_ctrl;

  irq_vec_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .src_i      (irq_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .pend_o     (pend),
    .mask_o     (mask),
    .ctrl_o     (ctrl),
    .wdog_vec_o (wdog_vec),
    .pvec0_o    (pvec0),
    .pvec1_o    (pvec1)
  );

  irq_vec_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i      (pend),
    .mask_i      (mask),
    .ctrl_i      (ctrl),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_ctrl_o  (win_ctrl)
  );

  irq_vec_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i, .rst_ni,
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .win_ctrl_i  (win_ctrl),
    .wdog_vec_i  (wdog_vec),
    .pvec0_i     (pvec0),
    .pvec1_i     (pvec1),
    .level_o     (irq_level_o),
    .vector_o    (irq_vector_o)
  );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 13
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_SRC:0]             src_i,
  input logic [NUM_SRC:0]             pend_i,
  input logic [NUM_SRC:0]             mask_i,
  input logic [NUM_SRC:1][CTRL_W-1:0] ctrl_i,
  input logic [VEC_W-1:0]             wdog_vec_i,
  input logic [VEC_W-1:0]             pvec0_i,
  input logic [VEC_W-1:0]             pvec1_i,
  input logic [LVL_W-1:0]             level_i,
  input logic [VEC_W-1:0]             vector_i
);
  // R5
  a_r5_idle_vector_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> (vector_i == '0));

  // R3
  a_r3_all_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i[NUM_SRC:1]) |=> (level_i == '0 && vector_i == '0));

  // R2
  a_r2_pending_tracks_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_i[NUM_SRC:1] == $past(src_i[NUM_SRC:1]) && pend_i[0] == 1'b0));

  // R9
  a_r9_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(pend_i) && $stable(mask_i) && $stable(ctrl_i) && $stable(wdog_vec_i)
     && $stable(pvec0_i) && $stable(pvec1_i))
    |=> ($stable(level_i) && $stable(vector_i)));

  // R3 / R5
  a_r3_level_needs_active_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != '0) |-> $past(|(pend_i[NUM_SRC:1] & ~mask_i[NUM_SRC:1])));
endmodule

bind irq_vec_ctrl irq_vec_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (irq_i),
  .pend_i     (pend),
  .mask_i     (mask),
  .ctrl_i     (ctrl),
  .wdog_vec_i (wdog_vec),
  .pvec0_i    (pvec0),
  .pvec1_i    (pvec1),
  .level_i    (irq_level_o),
  .vector_i   (irq_vector_o)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] irq_i = '0;
  logic        reg_we_i = 1'b0;
  logic [8:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [2:0]  irq_level_o;
  logic [7:0]  irq_vector_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_ctrl [1:NS];
  logic [13:0] m_mask;
  logic [7:0]  m_wdog, m_pv0, m_pv1;

  irq_vec_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] rst_ctrl(int n);
    case (n)
      1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;  4: return 8'h10;
      5: return 8'h14;  6: return 8'h18;  7: return 8'h1C;  8: return 8'h1C;
      9, 10, 11: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [10:0] expect_out(logic [13:0] pend);
    logic [4:0] bk = '0;
    int bi = 0;
    logic [2:0] lvl;
    logic [7:0] vec;
    for (int n = 1; n <= NS; n++)
      if (pend[n] && !m_mask[n] && m_ctrl[n][4:0] > bk) begin
        bk = m_ctrl[n][4:0];
        bi = n;
      end
    if (bk < 5'd4) return '0;
    lvl = m_ctrl[bi][4:2];
    if (m_ctrl[bi][7]) vec = 8'd24 + {5'd0, lvl};
    else if (bi == 8)  vec = m_wdog;
    else if (bi == 12) vec = m_pv0;
    else if (bi == 13) vec = m_pv1;
    else               vec = 8'h0F;
    return {lvl, vec};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, {21'd0, irq_level_o, irq_vector_o}, {21'd0, expect_out({irq_i[13:1], 1'b0})});
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    for (int n = 1; n <= NS; n++) if (a == 9'(9'h13 + n)) m_ctrl[n] = d[7:0];
    if (a == 9'h036) m_mask = d[13:0];
    if (a == 9'h042) m_wdog = d[7:0];
    if (a == 9'h170) m_pv0 = d[7:0];
    if (a == 9'h1B0) m_pv1 = d[7:0];
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_irq(logic [13:0] v);
    @(negedge clk_i);
    irq_i = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd5171));
    for (int n = 1; n <= NS; n++) m_ctrl[n] = rst_ctrl(n);
    m_mask = 14'h3FFE; m_wdog = 8'h0F; m_pv0 = '0; m_pv1 = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    chk("R1 level/vector", {irq_level_o, irq_vector_o}, 0);
    for (int n = 1; n <= NS; n++) begin
      rd(9'(9'h13 + n), d);
      chk("R1 ctrl reset", d, {8'd0, rst_ctrl(n)});
    end
    rd(9'h036, d); chk("R1 mask reset", d, 16'h3FFE);
    rd(9'h042, d); chk("R1 wdog vec reset", d, 16'h000F);
    rd(9'h170, d); chk("R1 pvec0 reset", d, 0);
    rd(9'h1B0, d); chk("R1 pvec1 reset", d, 0);
    rd(9'h100, d); chk("R8 unmapped read", d, 0);

    // R3 all masked
    set_irq(14'h3FFE); settle();
    chk("R3 all masked", {irq_level_o, irq_vector_o}, 0);
    rd(9'h03A, d); chk("R2 pending read", d, 16'h3FFE);

    // R4 tie between 7 and 8 (key 0x1C) -> 7 wins, non-autovec -> 0x0F
    wr(9'h036, 16'h0000); settle();
    chk("R4 tie lowest", {irq_level_o, irq_vector_o}, {3'd7, 8'h0F});

    // R7 watchdog vector
    set_irq(14'h0100); settle();
    chk("R7 wdog default", {irq_level_o, irq_vector_o}, {3'd7, 8'h0F});
    wr(9'h042, 16'h0040); settle();
    chk("R7 wdog vector", {irq_level_o, irq_vector_o}, {3'd7, 8'h40});

    // R5 key 0 autovec source suppressed
    set_irq(14'h0200); settle();
    chk("R5 key zero", {irq_level_o, irq_vector_o}, 0);
    // R6 autovector
    wr(9'h01C, 16'h0094); settle();
    chk("R6 autovector", {irq_level_o, irq_vector_o}, {3'd5, 8'd29});

    // R7 peripheral vectors
    wr(9'h01F, 16'h000C); wr(9'h170, 16'h0055);
    set_irq(14'h1000); settle();
    chk("R7 pvec0", {irq_level_o, irq_vector_o}, {3'd3, 8'h55});
    wr(9'h020, 16'h0010); wr(9'h1B0, 16'h00A7);
    set_irq(14'h2000); settle();
    chk("R7 pvec1", {irq_level_o, irq_vector_o}, {3'd4, 8'hA7});

    // R5 threshold: key 4 passes, key 3 suppressed
    set_irq(14'h0002); settle();
    chk("R5 key four", {irq_level_o, irq_vector_o}, {3'd1, 8'h0F});
    wr(9'h014, 16'h0003); settle();
    chk("R5 key three", {irq_level_o, irq_vector_o}, 0);
    set_irq(14'h0000); settle();
    chk("R5 none active", {irq_level_o, irq_vector_o}, 0);

    // R2 write to pending ignored
    wr(9'h03A, 16'hFFFF); settle();
    rd(9'h03A, d); chk("R2 pending write ignored", d, 0);
    chk("R2 outputs after pending write", {irq_level_o, irq_vector_o}, 0);

    // R9 latency: mask write
    set_irq(14'h0080); settle();
    chk("R9 before", {irq_level_o, irq_vector_o}, {3'd7, 8'h0F});
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 9'h036; reg_wdata_i = 16'h0080; m_mask = 14'h0080;
    @(negedge clk_i); reg_we_i = 1'b0;
    chk("R9 one cycle old", {irq_level_o, irq_vector_o}, {3'd7, 8'h0F});
    @(negedge clk_i);
    chk("R9 updated", {irq_level_o, irq_vector_o}, 0);
    // R9 latency: input change takes two edges (pending, then output)
    wr(9'h036, 16'h0000); settle();
    irq_i = 14'h0000;
    @(negedge clk_i);
    chk("R9 input first edge", {irq_level_o, irq_vector_o}, {3'd7, 8'h0F});
    @(negedge clk_i);
    chk("R9 input second edge", {irq_level_o, irq_vector_o}, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        wr(9'(9'h13 + $urandom_range(1, NS)), 16'($urandom_range(0, 255)));
      if ($urandom_range(0, 7) == 0)
        wr(9'h036, 16'($urandom) & 16'h3FFE & 16'($urandom));
      if ($urandom_range(0, 15) == 0)
        wr(9'h170, 16'($urandom_range(0, 255)));
      set_irq(14'($urandom) & 14'h3FFE);
      settle();
      chk_out("R4 random arbitration");
    end

    finish_run();
  end
endmodule